// File: doc/BRIEF.md
# Edge-Triggered Cycle-Count Reference Delay

This block watches a timing reference input and, after it sees the selected transition, emits a one-cycle event a programmed number of system-clock cycles later. It is the fixed-delay leg of a timing loop: the delayed event marks when a downstream comparator should expect the loop's feedback edge.

Two mode inputs act together. One picks the transition that counts: falling when high, rising when low. Combined with the second bit, it also picks one of four cycle counts. The reference input is asynchronous, so it passes through a synchronizer before edge detection. Only one count runs at a time. While it runs, further active edges and changes on the mode inputs are ignored.

Top module: `edge_delay_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy_o` and `evt_o` are low and the synchronizer holds a low level.
- R2: With `edge_sel` = 1 a high-to-low transition of `ref_in` starts a count, and a low-to-high transition starts nothing.
- R3: With `edge_sel` = 0 a low-to-high transition of `ref_in` starts a count, and a high-to-low transition starts nothing.
- R4: With the default two synchronizer stages, `busy_o` rises on the third rising clock edge after an active transition is presented on `ref_in`.
- R5: The count length is chosen by {`edge_sel`,`slow_sel`}: 2'b11 gives 9 cycles, 2'b10 gives 15, 2'b01 gives 26 and 2'b00 gives 32. `busy_o` stays high for exactly that many cycles.
- R6: `evt_o` is high for exactly one cycle. It rises on the same clock edge on which `busy_o` falls, and never rises while idle.
- R7: The mode bits are sampled on the edge that starts the count. Changing them while `busy_o` is high does not alter the running count.
- R8: An active transition that is detected while `busy_o` is high neither restarts the count nor produces a second event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Asynchronous timing reference |
| edge_sel | input | 1 | 1: falling edge active, 0: rising edge active; also selects the delay |
| slow_sel | input | 1 | Second delay-select bit |
| busy_o | output | 1 | High while a count is running |
| evt_o | output | 1 | One-cycle pulse when the count expires |

## Verification
On every cycle, the assertions check the following. The event is a single cycle and coincides with the end of busy. The block leaves reset idle. Each run of busy lasts exactly the count that belongs to the mode bits sampled at its start, and never runs longer. The bench scenarios are the only proof of the following points. The edge polarity is honoured and non-active transitions are ignored. The latency from the input pin to busy matches the synchronizer depth. Mode changes and extra active edges during a count leave both its length and the single event unchanged.

// File: rtl/edt_pkg.sv
// Package: shared mode encoding for the edge-triggered delay timer.
// Assumes: mode bits arrive as two independent single-bit inputs.
package edt_pkg;

    // Mode bundle: polarity/delay select plus the second delay select
    typedef struct packed {
        logic fall_edge;
        logic slow;
    } edt_mode_t;

    // Index of the four delay choices, msb = fall_edge
    function automatic logic [1:0] mode_idx(edt_mode_t m);
        return {m.fall_edge, m.slow};
    endfunction

endpackage

// File: rtl/edt_sync.sv
// Module: multi-stage synchronizer for an asynchronous level.
// Assumes: STAGES >= 1; all stages reset to low.
module edt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single-stage capture of the input
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= async_i;
            end
        end else begin : g_many
            // Shift the input through the chain of flops
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/edt_edge_det.sv
// Module: selectable-polarity edge detector on a synchronized level.
// Assumes: input is already synchronous to clk; history resets to low.
module edt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic fall_sel_i,
    output logic hit_o
);
    logic lvl_q;

    // Remember the previous synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_i;
    end

    // Flag the transition chosen by the polarity select
    always_comb begin
        if (fall_sel_i) hit_o = lvl_q & ~lvl_i;
        else            hit_o = ~lvl_q & lvl_i;
    end
endmodule

// File: rtl/edt_counter.sv
// Module: one-shot down counter that loads a mode-selected length.
// Assumes: every length parameter is >= 1 and fits in CNT_W bits;
//          a start while busy is dropped.
module edt_counter
    import edt_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int LEN_FALL_SL = 9,
    parameter int LEN_FALL_FA = 15,
    parameter int LEN_RISE_SL = 26,
    parameter int LEN_RISE_FA = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  edt_mode_t mode_i,
    output logic      busy_o,
    output logic      evt_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_len;

    // Pick the run length from the mode present at the start edge
    always_comb begin
        case (mode_idx(mode_i))
            2'b11:   load_len = CNT_W'(LEN_FALL_SL);
            2'b10:   load_len = CNT_W'(LEN_FALL_FA);
            2'b01:   load_len = CNT_W'(LEN_RISE_SL);
            default: load_len = CNT_W'(LEN_RISE_FA);
        endcase
    end

    // Run the count, pulse the event on expiry, ignore starts while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_o <= 1'b0;
            evt_o  <= 1'b0;
        end else begin
            evt_o <= 1'b0;
            if (busy_o) begin
                if (cnt_q == CNT_W'(1)) begin
                    busy_o <= 1'b0;
                    evt_o  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end else if (start_i) begin
                busy_o <= 1'b1;
                cnt_q  <= load_len;
            end
        end
    end
endmodule

// File: rtl/edge_delay_timer.sv
// Module: top of the edge-triggered cycle-count reference delay.
// Assumes: ref_in is asynchronous with widely spaced transitions;
//          edge_sel/slow_sel are sampled when a count starts.
module edge_delay_timer
    import edt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int D_FALL_SLOW = 9,
    parameter int D_FALL_FAST = 15,
    parameter int D_RISE_SLOW = 26,
    parameter int D_RISE_FAST = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic edge_sel,
    input  logic slow_sel,
    output logic busy_o,
    output logic evt_o
);
    localparam int MAX_A = (D_FALL_SLOW > D_FALL_FAST) ? D_FALL_SLOW : D_FALL_FAST;
    localparam int MAX_B = (D_RISE_SLOW > D_RISE_FAST) ? D_RISE_SLOW : D_RISE_FAST;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_D + 1);

    logic      ref_sync;
    logic      edge_hit;
    edt_mode_t mode;

    assign mode.fall_edge = edge_sel;
    assign mode.slow      = slow_sel;

    edt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ref_in),
        .sync_o  (ref_sync)
    );

    edt_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (ref_sync),
        .fall_sel_i (edge_sel),
        .hit_o      (edge_hit)
    );

    edt_counter #(
        .CNT_W       (CNT_W),
        .LEN_FALL_SL (D_FALL_SLOW),
        .LEN_FALL_FA (D_FALL_FAST),
        .LEN_RISE_SL (D_RISE_SLOW),
        .LEN_RISE_FA (D_RISE_FAST)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (edge_hit),
        .mode_i  (mode),
        .busy_o  (busy_o),
        .evt_o   (evt_o)
    );
endmodule

// File: rtl/edt_checker.sv
// Module: property checker for edge_delay_timer, bound to the top.
// Assumes: only the top-level ports are observed.
module edt_checker #(
    parameter int D_FS = 9,
    parameter int D_FF = 15,
    parameter int D_RS = 26,
    parameter int D_RF = 32
) (
    input logic clk,
    input logic rst_n,
    input logic edge_sel,
    input logic slow_sel,
    input logic busy_o,
    input logic evt_o
);
    logic es_q, ss_q, busy_q;
    int   run_len;
    int   exp_len;

    // Track the mode seen at each edge and the length of each busy run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            es_q    <= 1'b0;
            ss_q    <= 1'b0;
            busy_q  <= 1'b0;
            run_len <= 0;
            exp_len <= 0;
        end else begin
            es_q   <= edge_sel;
            ss_q   <= slow_sel;
            busy_q <= busy_o;
            if (busy_o && !busy_q) begin
                run_len <= 1;
                case ({es_q, ss_q})
                    2'b11:   exp_len <= D_FS;
                    2'b10:   exp_len <= D_FF;
                    2'b01:   exp_len <= D_RS;
                    default: exp_len <= D_RF;
                endcase
            end else if (busy_o) begin
                run_len <= run_len + 1;
            end
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !evt_o));

    a_r6_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);

    a_r6_evt_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (!busy_o && $past(busy_o)));

    a_r5_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (run_len == exp_len));

    a_r8_bounded_run: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_len <= exp_len));
endmodule

bind edge_delay_timer edt_checker #(
    .D_FS (D_FALL_SLOW),
    .D_FF (D_FALL_FAST),
    .D_RS (D_RISE_SLOW),
    .D_RF (D_RISE_FAST)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_sel (edge_sel),
    .slow_sel (slow_sel),
    .busy_o   (busy_o),
    .evt_o    (evt_o)
);

// File: tb/edge_delay_timer_bench.sv
module edge_delay_timer_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic edge_sel = 1'b0;
    logic slow_sel = 1'b0;
    logic busy_o, evt_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    edge_delay_timer u_edge_delay_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .edge_sel (edge_sel),
        .slow_sel (slow_sel),
        .busy_o   (busy_o),
        .evt_o    (evt_o)
    );

    function automatic int want_len(logic es, logic ss);
        if (es && ss)  return 9;
        if (es)        return 15;
        if (ss)        return 26;
        return 32;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // disturb: 0 none, 1 flip mode mid-count (R7), 2 extra active edge mid-count (R8)
    task automatic run_case(logic es, logic ss, int disturb);
        int lat;
        int len;
        int exp;
        exp = want_len(es, ss);
        @(negedge clk);
        edge_sel = es;
        slow_sel = ss;
        ref_in   = es;              // non-active transition towards the idle level
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(busy_o == 1'b0, es ? "R2 rise ignored" : "R3 fall ignored", busy_o, 0);
        end
        ref_in = ~es;               // active transition
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!busy_o && lat < 10);
        chk(lat == 3, "R4 latency", lat, 3);
        len = 1;
        forever begin
            @(negedge clk);
            if (!busy_o) break;
            len++;
            if (disturb == 1 && len == 3) begin
                edge_sel = ~es;
                slow_sel = ~ss;
            end
            if (disturb == 2 && len == 2) ref_in = es;
            if (disturb == 2 && len == 6) ref_in = ~es;
            if (len > 40) break;
        end
        chk(len == exp, disturb == 1 ? "R7 length" : "R5 length", len, exp);
        chk(evt_o == 1'b1, "R6 event high", evt_o, 1);
        @(negedge clk);
        chk(evt_o == 1'b0, "R6 event one cycle", evt_o, 0);
        if (disturb == 2) begin
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                chk(busy_o == 1'b0 && evt_o == 1'b0, "R8 no restart", busy_o, 0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk(busy_o == 1'b0 && evt_o == 1'b0, "R1 in reset", busy_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && evt_o == 1'b0, "R1 after reset", busy_o, 0);

        run_case(1'b1, 1'b1, 0);
        run_case(1'b1, 1'b0, 0);
        run_case(1'b0, 1'b1, 0);
        run_case(1'b0, 1'b0, 0);
        run_case(1'b1, 1'b1, 1);
        run_case(1'b0, 1'b0, 1);
        run_case(1'b1, 1'b0, 2);
        run_case(1'b0, 1'b1, 2);

        for (int k = 0; k < 24; k++) begin
            logic es, ss;
            int d;
            es = 1'($urandom % 2);
            ss = 1'($urandom % 2);
            d  = int'($urandom % 3);
            run_case(es, ss, d);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule